// File: doc/BRIEF.md
# Slave-Mode Serial Peripheral Shifter with Mode-Fault Flag

This block is the receive/transmit engine of a serial peripheral port that runs only as a slave. The serial select, serial clock and serial data-in pins are brought into the system-clock domain through two-flop synchronisers. Their edges are then detected with registered copies. The system clock must run at least four times faster than the serial clock. Each transfer moves an 8-bit byte, most-significant bit first. The serial data-out pin has a separate output enable, so the pad can be tri-stated. Either clock polarity and either clock phase can be chosen.

A simple strobe-based register port is used by the host. It writes a 7-bit control word and a transmit byte, reads the receive byte, and signals a status read. Four flags are kept: transmitter empty, receiver full, overflow and mode fault. The mode-fault flag depends on the clock phase. With phase 0, the select falling edge itself starts a transfer, so a select that rises again before the byte ends is a fault, even if no clock edge was seen. The flag clears only through a guarded sequence: a status read, then a control write, with the fault condition absent at the moment of that write. Three interrupt requests combine the flags with enable bits.

Top module: `sspi_slave`

## Requirements
- R1: Control word bits are [0] enable, [1] clock polarity, [2] clock phase, [3] transmit interrupt enable, [4] receive interrupt enable, [5] error interrupt enable, [6] mode-fault interrupt enable. Status bits are [0] transmitter empty, [1] receiver full, [2] overflow, [3] mode fault, and [7:4] read as zero. After reset the control word is zero, status reads 0x01, the data-out enable is low and all interrupt requests are low.
- R2: With phase 0 and enable set, a falling select starts a transfer. The transmit byte moves into the shifter, transmitter empty sets, and data-out shows the MSB before any clock edge. Data-in is sampled on leading clock edges and data-out changes on trailing edges. The byte completes at the eighth leading edge.
- R3: With phase 1, a falling select alone starts nothing, and transmitter empty keeps its value. The transfer starts at the first leading edge seen while select is low, and the MSB is presented at that edge. Data-out changes on leading edges and data-in is sampled on trailing edges. The transfer ends at the eighth trailing edge, when the clock returns to idle.
- R4: The idle clock level equals the polarity bit, and a leading edge is the clock leaving its idle level. Both polarities give the same byte-level results.
- R5: While select is high, the data-out enable is low. Every clock edge is ignored, even in the middle of a transfer, and the bit position reached so far is kept.
- R6: Mode fault sets when select is high while a transfer is in progress. With phase 0, a select low-then-high with no clock edges sets it. With phase 1, the same sequence does not. After a completed byte, raising select does not set it.
- R7: A mode fault neither clears enable nor resets the shifter. Lowering select again resumes the same transfer and does not reload it. Clearing enable ends the transfer, and setting it again allows a fresh start.
- R8: Mode fault clears only on a control write preceded by a status read made while the flag was set. The clear takes effect only if, at the write, enable is set with a transfer in progress and select high is not the case. A control write without that read leaves the flag set.
- R9: At byte completion, if receiver full is clear, the byte goes to the receive register and receiver full sets. Otherwise overflow sets and the byte is discarded, leaving the old byte. A receive-data read clears receiver full and overflow.
- R10: Writing the transmit byte clears transmitter empty.
- R11: The transmit request equals transmitter empty AND its enable, and the receive request equals receiver full AND its enable. The error request is asserted when the error enable is set and either overflow is set, or mode fault and the mode-fault enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Serial select pin, active low |
| sck | input | 1 | Serial clock pin |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the data-out pad |
| rd_status | input | 1 | Strobe: host read the status word |
| wr_ctrl | input | 1 | Strobe: write control word |
| ctrl_wdata | input | 7 | Control word to write |
| wr_txd | input | 1 | Strobe: write transmit byte |
| txd_wdata | input | 8 | Transmit byte to write |
| rd_rxd | input | 1 | Strobe: host read the receive byte |
| status_rdata | output | 8 | Status word |
| rxd_rdata | output | 8 | Receive byte |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench targets the phase-dependent start rule. A design that loads on the select edge in phase 1 drops transmitter empty too early. A design that waits for a clock in phase 0 shows a stale MSB and misses the no-clock fault. Edges toggled while select is high mid-byte must leave the received byte intact; a design that counts them corrupts it or completes early. The guarded clear is driven with a bare control write and with a write while the fault condition persists, both of which must leave the flag set. A second byte arriving into a full receiver must keep the first byte, not overwrite it.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam int CTL_EN    = 0;
  localparam int CTL_CPOL  = 1;
  localparam int CTL_CPHA  = 2;
  localparam int CTL_TXIE  = 3;
  localparam int CTL_RXIE  = 4;
  localparam int CTL_ERRIE = 5;
  localparam int CTL_MFEN  = 6;
  localparam int CTL_W     = 7;

  localparam int ST_TXE = 0;
  localparam int ST_RXF = 1;
  localparam int ST_OVF = 2;
  localparam int ST_MF  = 3;

  // clock level relative to idle: 0 = idle, 1 = active
  function automatic logic norm_lvl(input logic sclk, input logic cpol);
    return sclk ^ cpol;
  endfunction

  function automatic logic err_req(input logic ie, input logic mfen,
                                   input logic ovf, input logic mf);
    return ie & (ovf | (mfen & mf));
  endfunction
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/sspi_engine.sv
module sspi_engine import sspi_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              ss_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_buf,
  output logic              start_evt,
  output logic              byte_done,
  output logic              active,
  output logic              miso_bit,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-2:0] rx_sh;
  logic lvl, lvl_q, ss_q, lead, trail, ss_fall, sel, samp_e, shift_e;

  always_comb begin
    lvl       = norm_lvl(sclk_s, cpol);
    lead      = lvl & ~lvl_q;
    trail     = ~lvl & lvl_q;
    ss_fall   = ss_q & ~ss_s;
    sel       = en & ~ss_s;
    start_evt = sel & ~active & (cpha ? lead : ss_fall);
    samp_e    = sel & active & (cpha ? trail : lead);
    shift_e   = sel & active & (cpha ? lead : trail);
    byte_done = samp_e & (bit_cnt == LAST);
    rx_byte   = {rx_sh, mosi_s};
    miso_bit  = tx_sh[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      ss_q    <= 1'b1;
      active  <= 1'b0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      lvl_q <= lvl;
      ss_q  <= ss_s;
      if (!en) begin
        active  <= 1'b0;
        bit_cnt <= '0;
      end else if (start_evt) begin
        active  <= 1'b1;
        bit_cnt <= '0;
        tx_sh   <= tx_buf;
      end else begin
        if (shift_e) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (samp_e) begin
          rx_sh <= rx_byte[DATA_W-2:0];
          if (byte_done) begin
            active  <= 1'b0;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  // R5: an unselected slave does not advance its bit position
  assert_ss_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_s && en) |=> $stable(bit_cnt));

  // R2: a completed byte always ends the transfer
  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !active);
endmodule

// File: rtl/sspi_regs.sv
module sspi_regs import sspi_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_status,
  input  logic              wr_ctrl,
  input  logic [CTL_W-1:0]  ctrl_wdata,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] txd_wdata,
  input  logic              rd_rxd,
  input  logic              start_evt,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              active,
  input  logic              ss_s,
  output logic [CTL_W-1:0]  ctrl,
  output logic [DATA_W-1:0] tx_buf,
  output logic [DATA_W-1:0] rx_buf,
  output logic [7:0]        status,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  logic tx_empty, rx_full, ovf, mfault, armed, mf_cond;

  assign mf_cond = ctrl[CTL_EN] & active & ss_s;
  assign status  = {4'b0000, mfault, ovf, rx_full, tx_empty};
  assign irq_tx  = ctrl[CTL_TXIE] & tx_empty;
  assign irq_rx  = ctrl[CTL_RXIE] & rx_full;
  assign irq_err = err_req(ctrl[CTL_ERRIE], ctrl[CTL_MFEN], ovf, mfault);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      tx_buf   <= '0;
      rx_buf   <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      ovf      <= 1'b0;
      mfault   <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_wdata;
      if (wr_txd) begin
        tx_buf   <= txd_wdata;
        tx_empty <= 1'b0;
      end else if (start_evt) begin
        tx_empty <= 1'b1;
      end
      if (byte_done) begin
        if (rx_full) ovf <= 1'b1;
        else begin
          rx_buf  <= rx_byte;
          rx_full <= 1'b1;
        end
      end else if (rd_rxd) begin
        rx_full <= 1'b0;
        ovf     <= 1'b0;
      end
      if (mf_cond)               mfault <= 1'b1;
      else if (wr_ctrl && armed) mfault <= 1'b0;
      if (wr_ctrl)                  armed <= 1'b0;
      else if (rd_status && mfault) armed <= 1'b1;
    end
  end

  // R2: loading the shifter empties the transmit buffer
  assert_load_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !wr_txd) |=> tx_empty);

  // R8: the flag cannot clear while its condition persists
  assert_mf_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mfault && mf_cond) |=> mfault);

  // R6: the flag only rises after select was seen high mid-transfer
  assert_mf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfault) |-> $past(mf_cond));

  // R9: a byte landing in a full receiver is dropped
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rx_full) |=> (ovf && $stable(rx_buf)));
endmodule

// File: rtl/sspi_slave.sv
module sspi_slave import sspi_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              rd_status,
  input  logic              wr_ctrl,
  input  logic [CTL_W-1:0]  ctrl_wdata,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] txd_wdata,
  input  logic              rd_rxd,
  output logic [7:0]        status_rdata,
  output logic [DATA_W-1:0] rxd_rdata,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  logic [2:0]        pins_s;
  logic              ss_s, sclk_s, mosi_s;
  logic [CTL_W-1:0]  ctrl;
  logic [DATA_W-1:0] tx_buf, rx_byte;
  logic              start_evt, byte_done, active;

  sspi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, sck, mosi}), .q(pins_s));
  assign {ss_s, sclk_s, mosi_s} = pins_s;

  sspi_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(ctrl[CTL_EN]), .cpol(ctrl[CTL_CPOL]),
    .cpha(ctrl[CTL_CPHA]), .ss_s(ss_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .tx_buf(tx_buf), .start_evt(start_evt), .byte_done(byte_done),
    .active(active), .miso_bit(miso), .rx_byte(rx_byte));

  sspi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_status(rd_status), .wr_ctrl(wr_ctrl),
    .ctrl_wdata(ctrl_wdata), .wr_txd(wr_txd), .txd_wdata(txd_wdata),
    .rd_rxd(rd_rxd), .start_evt(start_evt), .byte_done(byte_done),
    .rx_byte(rx_byte), .active(active), .ss_s(ss_s), .ctrl(ctrl),
    .tx_buf(tx_buf), .rx_buf(rxd_rdata), .status(status_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  assign miso_oe = ctrl[CTL_EN] & ~ss_s;

  // R11: no error request without the error enable
  assert_err_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> ctrl[CTL_ERRIE]);
endmodule

// File: tb/sspi_slave_bench.sv
module sspi_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic rd_status = 1'b0, wr_ctrl = 1'b0, wr_txd = 1'b0, rd_rxd = 1'b0;
  logic [6:0] ctrl_wdata = '0;
  logic [7:0] txd_wdata = '0;
  logic [7:0] status_rdata, rxd_rdata;
  logic irq_tx, irq_rx, irq_err;

  int checks = 0;
  int errors = 0;
  logic cpol_b = 1'b0, cpha_b = 1'b0;
  logic [7:0] exp_q[$];
  logic rxf_q = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sspi_slave u_sspi_slave (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .rd_status(rd_status), .wr_ctrl(wr_ctrl),
    .ctrl_wdata(ctrl_wdata), .wr_txd(wr_txd), .txd_wdata(txd_wdata),
    .rd_rxd(rd_rxd), .status_rdata(status_rdata), .rxd_rdata(rxd_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_ctrl(input logic [6:0] v);
    @(negedge clk); ctrl_wdata = v; wr_ctrl = 1'b1;
    @(negedge clk); wr_ctrl = 1'b0;
  endtask
  task automatic bus_txd(input logic [7:0] v);
    @(negedge clk); txd_wdata = v; wr_txd = 1'b1;
    @(negedge clk); wr_txd = 1'b0;
  endtask
  task automatic bus_rdst();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask
  task automatic bus_rdrx();
    @(negedge clk); rd_rxd = 1'b1;
    @(negedge clk); rd_rxd = 1'b0;
  endtask

  task automatic sel(input logic v);
    ss_n = v; wclk(HALF);
  endtask

  task automatic spi_bit(input logic mo, output logic mi);
    if (!cpha_b) begin
      mosi = mo; wclk(HALF);
      mi = miso; sck = ~cpol_b; wclk(HALF);
      sck = cpol_b;
    end else begin
      sck = ~cpol_b; mosi = mo; wclk(HALF);
      mi = miso; sck = cpol_b; wclk(HALF);
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) spi_bit(mo[i], mi[i]);
    wclk(HALF);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: each rising receiver-full pops one expected byte (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && status_rdata[1] && !rxf_q) begin
        if (exp_q.size() == 0) chk("R9 unexpected byte", {24'b0, rxd_rdata}, 32'hFFFF_FFFF);
        else chk("R9 received byte", {24'b0, rxd_rdata}, {24'b0, exp_q.pop_front()});
      end
      rxf_q = status_rdata[1];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] mi;
    logic b;
    wclk(3); rst_n = 1'b1; wclk(2);

    // R1 reset state
    chk("R1 status after reset", status_rdata, 8'h01);
    chk("R1 oe after reset", miso_oe, 0);
    chk("R1 irqs after reset", {irq_tx, irq_rx, irq_err}, 0);

    // phase 0, polarity 0
    bus_txd(8'hA5);
    chk("R10 tx write clears empty", status_rdata[0], 0);
    bus_ctrl(7'h01);
    sel(1'b0);
    chk("R5 oe when selected", miso_oe, 1);
    chk("R2 msb before clock", miso, 1);
    chk("R2 load sets empty", status_rdata[0], 1);
    exp_q.push_back(8'h3C);
    spi_byte(8'h3C, mi);
    chk("R2 phase0 out byte", mi, 8'hA5);
    chk("R9 receiver full", status_rdata[1], 1);
    sel(1'b1);
    chk("R6 no fault after full byte", status_rdata[3], 0);
    bus_rdrx();
    chk("R9 read clears full", status_rdata[1], 0);

    // phase 1, polarity 1
    sck = 1'b1; wclk(4);
    cpol_b = 1'b1; cpha_b = 1'b1;
    bus_txd(8'h5A);
    bus_ctrl(7'h07);
    sel(1'b0);
    chk("R3 select alone no load", status_rdata[0], 0);
    exp_q.push_back(8'hC3);
    spi_byte(8'hC3, mi);
    chk("R3 R4 phase1 pol1 out byte", mi, 8'h5A);
    chk("R3 load on first edge", status_rdata[0], 1);
    sel(1'b1);
    sel(1'b0);
    sel(1'b1);
    chk("R6 phase1 no clocks no fault", status_rdata[3], 0);
    bus_rdrx();

    // phase 0 mode fault without clocks
    sck = 1'b0; wclk(4);
    cpol_b = 1'b0; cpha_b = 1'b0;
    bus_ctrl(7'h21);
    sel(1'b0);
    sel(1'b1);
    chk("R6 phase0 no clocks fault", status_rdata[3], 1);
    chk("R11 fault masked by mf enable", irq_err, 0);
    bus_ctrl(7'h61);
    chk("R11 fault raises error irq", irq_err, 1);
    chk("R8 write without read keeps", status_rdata[3], 1);
    bus_txd(8'h42);
    sel(1'b0);
    chk("R7 no reload after fault", status_rdata[0], 0);
    sel(1'b1);
    bus_rdst();
    bus_ctrl(7'h60);
    chk("R8 clear blocked by condition", status_rdata[3], 1);
    bus_rdst();
    bus_ctrl(7'h61);
    chk("R8 guarded clear", status_rdata[3], 0);
    chk("R11 error irq drops", irq_err, 0);
    sel(1'b0);
    chk("R7 fresh start after abort", status_rdata[0], 1);
    exp_q.push_back(8'h5E);
    spi_byte(8'h5E, mi);
    chk("R7 byte after abort", mi, 8'h42);
    sel(1'b1);

    // overflow: second byte into full receiver
    sel(1'b0);
    spi_byte(8'h22, mi);
    sel(1'b1);
    chk("R9 overflow set", status_rdata[2], 1);
    chk("R9 old byte kept", rxd_rdata, 8'h5E);
    chk("R11 overflow error irq", irq_err, 1);
    bus_rdrx();
    chk("R9 read clears full and ovf", status_rdata[2:1], 0);

    // phase 1: edges ignored while unselected mid-byte
    cpha_b = 1'b1;
    bus_ctrl(7'h05);
    bus_txd(8'hF0);
    exp_q.push_back(8'h96);
    sel(1'b0);
    for (int i = 7; i >= 4; i--) begin
      spi_bit(8'h96 >> i, b); mi[i] = b;
    end
    sel(1'b1);
    chk("R5 oe low while unselected", miso_oe, 0);
    mosi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
    end
    chk("R6 phase1 mid-byte fault", status_rdata[3], 1);
    sel(1'b0);
    for (int i = 3; i >= 0; i--) begin
      spi_bit(8'h96 >> i, b); mi[i] = b;
    end
    wclk(HALF);
    chk("R5 ignored edges keep position", mi, 8'hF0);
    sel(1'b1);
    bus_rdst();
    bus_ctrl(7'h05);
    chk("R8 clear after byte ends", status_rdata[3], 0);
    bus_rdrx();

    // interrupt enables
    cpha_b = 1'b0;
    bus_ctrl(7'h19);
    chk("R11 tx request", irq_tx, 1);
    chk("R11 rx request idle", irq_rx, 0);
    bus_txd(8'h11);
    chk("R10 R11 tx request drops", irq_tx, 0);
    exp_q.push_back(8'h77);
    sel(1'b0);
    spi_byte(8'h77, mi);
    sel(1'b1);
    chk("R11 rx request", irq_rx, 1);
    chk("R9 all bytes seen", exp_q.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule